// File: doc/BRIEF.md
# Bit-Serial Adder-Subtractor

This block adds or subtracts two 4-bit operands one bit position per clock. The operands arrive serially, least significant bit first. A mode input picks addition or subtraction. One carry flip-flop joins adjacent bit positions. When an operation starts, this flip-flop is preset from the mode: 0 for addition and 1 for subtraction. In subtract mode each Y bit is also inverted before the full-adder logic, so the datapath forms X + ~Y + 1. That is two's-complement subtraction on the same serial hardware.

Each result bit enters a shift register at its most significant end, and the register shifts toward bit 0. After four bits have been processed, the register holds the whole result in normal bit order. A done flag is high for one cycle when the result is complete. The carry out of the last position is dropped, and a negative difference appears only as its 4-bit two's-complement pattern.

The controller has three states:

- `ST_IDLE`: waiting for work.
- `ST_RUN`: one bit position is processed per cycle.
- `ST_DONE`: the single cycle in which `done` is high.

The transitions are:

- `ST_IDLE` to `ST_RUN` on `start`.
- `ST_RUN` to `ST_RUN` while bits remain.
- `ST_RUN` to `ST_DONE` after the fourth bit.
- `ST_DONE` to `ST_RUN` when `start` arrives in the done cycle (back-to-back operation).
- `ST_DONE` to `ST_IDLE` otherwise.

Top module: `serial_addsub`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `result` to 0000 and `done` to 0, and abandons any operation in progress.
- R2: With `sub_mode`=0 at the start cycle, the carry is cleared to 0, and the block returns (X + Y) mod 16. For example, 0011 + 0001 gives 0100.
- R3: With `sub_mode`=1 at the start cycle, the carry is set to 1 and every Y bit is inverted, so the block returns (X - Y) mod 16. For example, 0101 - 0011 gives 0010.
- R4: Bit i of each operand is presented in the i-th cycle after the start cycle (i = 0 is the least significant bit). Each result bit enters `result[3]`, and the earlier bits move one place toward bit 0, so the first computed bit ends in `result[0]`.
- R5: `done` is 1 for exactly one cycle, the cycle after the fourth bit is consumed, and `result` is valid in that cycle. `done` is 0 while bits are being processed.
- R6: The final carry out is discarded, and no flag is raised. 0011 - 0101 gives 1110, and 1111 + 0001 gives 0000.
- R7: `sub_mode` is sampled only in the start cycle. Changing it during the four bit cycles does not change the result.
- R8: A `start` pulse while bits are being processed is ignored. The running operation completes with its correct result, and `done` comes at its normal cycle.
- R9: A `start` pulse in the done cycle begins a new operation at once. The next four cycles are that operation's bit cycles.
- R10: Outside the bit cycles, `result` holds its value whatever `x_bit` and `y_bit` do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins an operation; accepted when idle or in the done cycle |
| x_bit | input | 1 | Serial bit of operand X, least significant bit first |
| y_bit | input | 1 | Serial bit of operand Y, least significant bit first |
| sub_mode | input | 1 | 0 = add, 1 = subtract; sampled with `start` |
| result | output | 4 | Parallel result from the shift register |
| done | output | 1 | One-cycle pulse when `result` is complete |

## Verification
Two events can fall in the same cycle: the completion of one operation, with `done` high and the result final, and the acceptance of the next `start`. The bench provokes this by raising `start` during the done cycle. In that cycle it checks the first result and `done`. It then checks that the second operation runs for exactly four bit cycles and yields its own correct value. It also raises `start` in the middle of an operation, where the request must be ignored and the result must be unaffected.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } addsub_state_e;
endpackage

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
    import addsub_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic mode_in,
    output logic load,
    output logic shift_en,
    output logic mode_q,
    output logic done_o
);
    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    addsub_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_RUN : ST_IDLE;
            ST_RUN:  state_d = (cnt_q == LAST) ? ST_DONE : ST_RUN;
            ST_DONE: state_d = start ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register, bit counter and sampled mode
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) begin
                cnt_q  <= '0;
                mode_q <= mode_in;
            end else if (shift_en) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Moore outputs plus start acceptance
    always_comb begin
        shift_en = (state_q == ST_RUN);
        done_o   = (state_q == ST_DONE);
        load     = start && (state_q != ST_RUN);
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (state_q == ST_IDLE && !done_o));

    a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r5_done_after_last: assert property (@(posedge clk) disable iff (rst)
        (shift_en && cnt_q == LAST) |=> done_o);

    a_r8_run_not_restarted: assert property (@(posedge clk) disable iff (rst)
        (shift_en && cnt_q != LAST) |=> (shift_en && cnt_q == $past(cnt_q) + 1'b1));

    a_r7_mode_held: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> $stable(mode_q));
endmodule

// File: rtl/addsub_bitcell.sv
module addsub_bitcell (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic preset,
    input  logic en,
    input  logic mode_q,
    input  logic x_in,
    input  logic y_in,
    output logic sum
);
    logic carry_q;
    logic y_eff;
    logic carry_d;

    always_comb begin
        y_eff   = y_in ^ mode_q;
        sum     = x_in ^ y_eff ^ carry_q;
        carry_d = (x_in & y_eff) | (x_in & carry_q) | (y_eff & carry_q);
    end

    always_ff @(posedge clk) begin
        if (rst)       carry_q <= 1'b0;
        else if (load) carry_q <= preset;
        else if (en)   carry_q <= carry_d;
    end

    a_r2_add_preset: assert property (@(posedge clk) disable iff (rst)
        (load && !preset) |=> (carry_q == 1'b0));

    a_r3_sub_preset: assert property (@(posedge clk) disable iff (rst)
        (load && preset) |=> (carry_q == 1'b1));
endmodule

// File: rtl/addsub_shreg.sv
module addsub_shreg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             din,
    output logic [WIDTH-1:0] q
);
    generate
        if (WIDTH > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (rst)     q <= '0;
                else if (en) q <= {din, q[WIDTH-1:1]};
            end
            a_r4_shift_down: assert property (@(posedge clk) disable iff (rst)
                en |=> (q[WIDTH-2:0] == $past(q[WIDTH-1:1])));
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (rst)     q <= '0;
                else if (en) q <= din;
            end
        end
    endgenerate

    a_r4_enter_msb: assert property (@(posedge clk) disable iff (rst)
        en |=> (q[WIDTH-1] == $past(din)));

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!en && !$past(rst)) |=> $stable(q));
endmodule

// File: rtl/serial_addsub.sv
module serial_addsub #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             x_bit,
    input  logic             y_bit,
    input  logic             sub_mode,
    output logic [WIDTH-1:0] result,
    output logic             done
);
    logic load;
    logic shift_en;
    logic mode_q;
    logic sum_bit;

    addsub_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .mode_in  (sub_mode),
        .load     (load),
        .shift_en (shift_en),
        .mode_q   (mode_q),
        .done_o   (done)
    );

    addsub_bitcell u_cell (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .preset (sub_mode),
        .en     (shift_en),
        .mode_q (mode_q),
        .x_in   (x_bit),
        .y_in   (y_bit),
        .sum    (sum_bit)
    );

    addsub_shreg #(.WIDTH(WIDTH)) u_sreg (
        .clk (clk),
        .rst (rst),
        .en  (shift_en),
        .din (sum_bit),
        .q   (result)
    );
endmodule

// File: tb/tb_serial_addsub.sv
module tb_serial_addsub;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       x_bit = 1'b0;
    logic       y_bit = 1'b0;
    logic       sub_mode = 1'b0;
    logic [3:0] result;
    logic       done;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    serial_addsub dut (
        .clk(clk), .rst(rst), .start(start), .x_bit(x_bit), .y_bit(y_bit),
        .sub_mode(sub_mode), .result(result), .done(done)
    );

    always #10 clk = ~clk;

    // entry layout: {sub, x[3:0], y[3:0], expected[3:0]}
    localparam logic [12:0] VEC [10] = '{
        {1'b0, 4'b0011, 4'b0001, 4'b0100},
        {1'b0, 4'b0001, 4'b0011, 4'b0100},
        {1'b0, 4'b0101, 4'b0010, 4'b0111},
        {1'b0, 4'b1111, 4'b0001, 4'b0000},
        {1'b0, 4'b0111, 4'b1001, 4'b0000},
        {1'b1, 4'b0101, 4'b0011, 4'b0010},
        {1'b1, 4'b0011, 4'b0101, 4'b1110},
        {1'b1, 4'b0000, 4'b0001, 4'b1111},
        {1'b1, 4'b1010, 4'b1010, 4'b0000},
        {1'b1, 4'b1001, 4'b0010, 4'b0111}
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // called at a negedge: raise start for one edge
    task automatic go(input logic sub);
        start = 1'b1;
        sub_mode = sub;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    // feed four bits LSB first; ends at negedge after the done edge
    task automatic feed(input logic [3:0] x, input logic [3:0] y,
                        input logic flipz, input logic poke);
        for (int i = 0; i < 4; i++) begin
            x_bit = x[i];
            y_bit = y[i];
            if (flipz) sub_mode = ~sub_mode;
            start = (poke && i == 1);
            check("R5 done low during bits", {3'b0, done}, 4'b0);
            @(posedge clk);
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    task automatic run_op(input string req, input logic sub, input logic [3:0] x,
                          input logic [3:0] y, input logic [3:0] exp,
                          input logic flipz, input logic poke);
        go(sub);
        feed(x, y, flipz, poke);
        check("R5 done pulse", {3'b0, done}, 4'b1);
        check(req, result, exp);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                bad++;
                total++;
                $display("FAIL R5 watchdog expired actual=hung expected=finish");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [3:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 reset result", result, 4'b0000);
        check("R1 reset done", {3'b0, done}, 4'b0);

        // R2 R3 R6: vector table
        foreach (VEC[k]) begin
            run_op(VEC[k][12] ? "R3/R6 subtract" : "R2/R6 add",
                   VEC[k][12], VEC[k][11:8], VEC[k][7:4], VEC[k][3:0], 1'b0, 1'b0);
            @(negedge clk);
            check("R5 done drops", {3'b0, done}, 4'b0);
        end

        // R4: bit order, asymmetric pattern 0001 + 0000 = 0001
        run_op("R4 lsb lands at bit0", 1'b0, 4'b0001, 4'b0000, 4'b0001, 1'b0, 1'b0);
        @(negedge clk);

        // R10: result holds while idle
        held = result;
        for (int i = 0; i < 6; i++) begin
            x_bit = i[0];
            y_bit = ~i[0];
            @(negedge clk);
        end
        check("R10 hold while idle", result, held);

        // R7: mode toggled during bits is ignored
        run_op("R7 mode sampled at start", 1'b1, 4'b0101, 4'b0011, 4'b0010, 1'b1, 1'b0);
        @(negedge clk);
        run_op("R7 mode sampled at start add", 1'b0, 4'b0011, 4'b0001, 4'b0100, 1'b1, 1'b0);
        @(negedge clk);

        // R8: start mid-operation ignored
        run_op("R8 start while busy", 1'b0, 4'b0101, 4'b0010, 4'b0111, 1'b0, 1'b1);
        @(negedge clk);
        check("R8 no extra done", {3'b0, done}, 4'b0);

        // R9: start in the done cycle
        run_op("R9 first of pair", 1'b1, 4'b0011, 4'b0101, 4'b1110, 1'b0, 1'b0);
        run_op("R9 second of pair", 1'b0, 4'b0110, 4'b0011, 4'b1001, 1'b0, 1'b0);
        @(negedge clk);
        check("R9 done single", {3'b0, done}, 4'b0);

        // R1: reset abandons an operation
        go(1'b0);
        x_bit = 1'b1; y_bit = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset mid-op result", result, 4'b0000);
        repeat (4) @(negedge clk);
        check("R1 no done after reset", {3'b0, done}, 4'b0);
        check("R1 result stays clear", result, 4'b0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule